// File: doc/BRIEF.md
# Flash Command Interface Front End

This block is the command-decoding front end of a parallel NOR-style flash device model. A host writes 16-bit command words over the chip-select and write-strobe pins. The block decodes them, keeps track of what a read returns (array contents, the status register, or identifier codes), and runs the two-cycle sequences for block erase, word program and block lock configuration. Accepted operations go to a stub write engine. The engine holds a small word array with one lock bit per block, a busy counter that stands in for program and erase time, and the sticky status register.

The bus pins are plain strobes, not a valid/ready stream. A write happens on every rising clock edge where select and write strobe are both low. No back-pressure path exists: a host must poll the ready bit in the status register. Reads are combinational from the current read mode while select and read strobe are low. An active-low reset pin doubles as deep power-down. A supply-lockout input forces reads back to the array. A programming-voltage-valid input gates the destructive operations.

Top module: `flash_cmd_if`

## Requirements
- R1: While `rst_n` is low, `rdata_oe_o` and `rdata_o` are 0 and no write has any effect. After reset, reads return the array (every word 0xFFFF) and the status register reads 0x80.
- R2: A write is taken only on a clock edge where both `cs_n` and `wr_n` are low. When either one is high, the word on `wdata_i` is ignored.
- R3: After `rst_n` rises, the first WAKE_CYC rising edges reject writes. The write at edge WAKE_CYC+1 is the first one accepted.
- R4: Command 0xFF selects array reads, 0x70 selects status reads and 0x90 selects identifier reads. A status read returns the status in bits 7:0 with bits 15:8 zero. An identifier read returns MFR_ID when `addr_i[0]`=0 and DEV_ID when it is 1.
- R5: Word program is 0x40 (or 0x10) followed by a data cycle at the target address. Reads switch to status, and status bit 7 is 0 (busy) for BUSY_CYC cycles. When the cycles end, the word becomes old AND new data.
- R6: Block erase is 0x20 followed by 0xD0. It sets every word of the addressed block of 2^BLK_LOG2 words to 0xFFFF. If any other second word follows 0x20 or 0x60, no operation runs, status bits 5 and 4 are set, and reads switch to status.
- R7: 0x60 then 0x01 sets the lock bit of the addressed block. 0x60 then 0xD0 clears all lock bits. An erase or program aimed at a locked block does not run and does not go busy. Instead it sets status bit 1 plus bit 5 (erase) or bit 4 (program), and the array is left unchanged.
- R8: If `vpp_ok_i` is low when an operation starts, the operation aborts at once. It sets status bit 3 plus bit 5 (erase, lock clear) or bit 4 (program, lock set), and the array is left unchanged.
- R9: While busy, only 0x70 is honoured. Every other write, including 0xFF and 0x50, is ignored.
- R10: After an operation ends, reads keep returning status until 0xFF is written. Changes on `vpp_ok_i` or `cs_n` do not alter this.
- R11: While `lockout_i` is high, reads return to array mode, any pending first cycle is dropped, and writes are ignored.
- R12: Command 0x50 clears status bits 5, 4, 3 and 1. A low pulse on `rst_n` also clears the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset and deep power-down |
| lockout_i | input | 1 | Supply-low lockout |
| vpp_ok_i | input | 1 | Programming voltage valid |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr_i | input | AW | Word address |
| wdata_i | input | 16 | Command or program data |
| rdata_o | output | 16 | Read data, 0 when not driven |
| rdata_oe_o | output | 1 | Read data valid (output enable) |

## Verification
The hardest case to reach from the ports is a setup command left pending when a supply lockout arrives. Nothing on the read path shows the dropped pending state directly. The stimulus issues 0x40 at one address, pulses the lockout, then writes 0x70 and afterwards 0xFF. If the setup had survived, 0x0070 would be programmed into the word, so reading that word back as 0xFFFF proves the setup was dropped. The wake-up window is found at the exact edge: a write is placed on edge WAKE_CYC after reset release and must be lost, and the write on the next edge must be taken.

// File: rtl/fci_pkg.sv
package fci_pkg;
  typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_IDENT} rd_mode_t;
  typedef enum logic [1:0] {PN_NONE, PN_ERASE, PN_PROG, PN_LOCK} pend_t;
  typedef enum logic [1:0] {OP_ERASE, OP_PROG, OP_LKSET, OP_LKCLR} op_t;

  localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_RD_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT = 8'h50;
  localparam logic [7:0] CMD_RD_ID    = 8'h90;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_PROG     = 8'h40;
  localparam logic [7:0] CMD_PROG_ALT = 8'h10;
  localparam logic [7:0] CMD_LOCK     = 8'h60;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
  localparam logic [7:0] CMD_LK_SET   = 8'h01;
endpackage

// File: rtl/fci_wake.sv
module fci_wake #(
  parameter int WAKE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready_o
);
  localparam int CW = $clog2(WAKE_CYC + 2);
  localparam logic [CW-1:0] LIMIT = CW'(WAKE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == LIMIT);
endmodule

// File: rtl/fci_cmd.sv
module fci_cmd
  import fci_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic          lockout_i,
  input  logic          busy_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   data_i,
  output rd_mode_t      mode_o,
  output logic          start_o,
  output op_t           op_o,
  output logic [AW-1:0] op_addr_o,
  output logic [15:0]   op_data_o,
  output logic          seq_err_o,
  output logic          clr_o
);
  rd_mode_t   mode_q, mode_n;
  pend_t      pend_q, pend_n;
  logic [7:0] cmd;

  assign cmd       = data_i[7:0];
  assign op_addr_o = addr_i;
  assign op_data_o = data_i;
  assign mode_o    = mode_q;

  always_comb begin
    mode_n    = mode_q;
    pend_n    = pend_q;
    start_o   = 1'b0;
    seq_err_o = 1'b0;
    clr_o     = 1'b0;
    op_o      = OP_PROG;
    if (lockout_i) begin
      mode_n = RD_ARRAY;
      pend_n = PN_NONE;
    end else if (wr_i) begin
      if (busy_i) begin
        if (cmd == CMD_RD_STAT) mode_n = RD_STATUS;
      end else if (pend_q != PN_NONE) begin
        pend_n = PN_NONE;
        mode_n = RD_STATUS;
        case (pend_q)
          PN_ERASE: begin
            if (cmd == CMD_CONFIRM) begin
              start_o = 1'b1;
              op_o    = OP_ERASE;
            end else seq_err_o = 1'b1;
          end
          PN_PROG: begin
            start_o = 1'b1;
            op_o    = OP_PROG;
          end
          PN_LOCK: begin
            if (cmd == CMD_LK_SET) begin
              start_o = 1'b1;
              op_o    = OP_LKSET;
            end else if (cmd == CMD_CONFIRM) begin
              start_o = 1'b1;
              op_o    = OP_LKCLR;
            end else seq_err_o = 1'b1;
          end
          default: ;
        endcase
      end else begin
        case (cmd)
          CMD_RD_ARRAY: mode_n = RD_ARRAY;
          CMD_RD_STAT:  mode_n = RD_STATUS;
          CMD_RD_ID:    mode_n = RD_IDENT;
          CMD_CLR_STAT: clr_o  = 1'b1;
          CMD_ERASE: begin
            pend_n = PN_ERASE;
            mode_n = RD_STATUS;
          end
          CMD_PROG, CMD_PROG_ALT: begin
            pend_n = PN_PROG;
            mode_n = RD_STATUS;
          end
          CMD_LOCK: begin
            pend_n = PN_LOCK;
            mode_n = RD_STATUS;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RD_ARRAY;
      pend_q <= PN_NONE;
    end else begin
      mode_q <= mode_n;
      pend_q <= pend_n;
    end
  end

  AST_LOCKOUT_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    lockout_i |=> (mode_q == RD_ARRAY && pend_q == PN_NONE)); // R11

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && busy_i && !lockout_i && cmd != CMD_RD_STAT) |=> $stable(mode_q)); // R9

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o); // R5
endmodule

// File: rtl/fci_wsm.sv
module fci_wsm
  import fci_pkg::*;
#(
  parameter int AW       = 4,
  parameter int BLK_LOG2 = 2,
  parameter int BUSY_CYC = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vpp_ok_i,
  input  logic          start_i,
  input  op_t           op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   data_i,
  input  logic          seq_err_i,
  input  logic          clr_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          busy_o,
  output logic [7:0]    status_o,
  output logic [15:0]   rd_data_o
);
  localparam int DEPTH = 1 << AW;
  localparam int BW    = AW - BLK_LOG2;
  localparam int NBLK  = 1 << BW;
  localparam int CW    = $clog2(BUSY_CYC + 1);

  logic [15:0]   mem_q [DEPTH];
  logic [NBLK-1:0] lock_q;
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  op_t           lat_op_q;
  logic [AW-1:0] lat_addr_q;
  logic [15:0]   lat_data_q;
  logic          ers_q, prg_q, vpp_q, lck_q;

  logic          ers_kind, guarded;
  logic [BW-1:0] lat_blk;

  assign ers_kind = (op_i == OP_ERASE) || (op_i == OP_LKCLR);
  assign guarded  = ((op_i == OP_ERASE) || (op_i == OP_PROG)) && lock_q[addr_i[AW-1:BLK_LOG2]];
  assign lat_blk  = lat_addr_q[AW-1:BLK_LOG2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
      lock_q     <= '0;
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      lat_op_q   <= OP_ERASE;
      lat_addr_q <= '0;
      lat_data_q <= '0;
      ers_q      <= 1'b0;
      prg_q      <= 1'b0;
      vpp_q      <= 1'b0;
      lck_q      <= 1'b0;
    end else begin
      if (clr_i) begin
        ers_q <= 1'b0;
        prg_q <= 1'b0;
        vpp_q <= 1'b0;
        lck_q <= 1'b0;
      end
      if (seq_err_i) begin
        ers_q <= 1'b1;
        prg_q <= 1'b1;
      end
      if (start_i) begin
        if (!vpp_ok_i || guarded) begin
          if (!vpp_ok_i) vpp_q <= 1'b1;
          else lck_q <= 1'b1;
          if (ers_kind) ers_q <= 1'b1;
          else prg_q <= 1'b1;
        end else begin
          busy_q     <= 1'b1;
          cnt_q      <= CW'(BUSY_CYC - 1);
          lat_op_q   <= op_i;
          lat_addr_q <= addr_i;
          lat_data_q <= data_i;
        end
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          case (lat_op_q)
            OP_ERASE: begin
              for (int i = 0; i < DEPTH; i++)
                if ((AW'(i) >> BLK_LOG2) == AW'(lat_blk)) mem_q[i] <= '1;
            end
            OP_PROG:  mem_q[lat_addr_q] <= mem_q[lat_addr_q] & lat_data_q;
            OP_LKSET: lock_q[lat_blk] <= 1'b1;
            OP_LKCLR: lock_q <= '0;
            default: ;
          endcase
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign status_o  = {~busy_q, 1'b0, ers_q, prg_q, vpp_q, 1'b0, lck_q, 1'b0};
  assign rd_data_o = mem_q[rd_addr_i];

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ers_q) |-> $past(clr_i)); // R12
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import fci_pkg::*;
#(
  parameter int          AW       = 4,
  parameter int          BLK_LOG2 = 2,
  parameter int          BUSY_CYC = 6,
  parameter int          WAKE_CYC = 4,
  parameter logic [15:0] MFR_ID   = 16'h00B0,
  parameter logic [15:0] DEV_ID   = 16'h00EC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lockout_i,
  input  logic          vpp_ok_i,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   wdata_i,
  output logic [15:0]   rdata_o,
  output logic          rdata_oe_o
);
  logic          wake_rdy, wr;
  rd_mode_t      mode;
  logic          start, seq_err, clr, busy;
  op_t           op;
  logic [AW-1:0] op_addr;
  logic [15:0]   op_data, arr_word, rd_word;
  logic [7:0]    status;

  assign wr = wake_rdy & ~cs_n & ~wr_n;

  fci_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk(clk), .rst_n(rst_n), .ready_o(wake_rdy)
  );

  fci_cmd #(.AW(AW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_i(wr), .lockout_i(lockout_i), .busy_i(busy),
    .addr_i(addr_i), .data_i(wdata_i), .mode_o(mode), .start_o(start),
    .op_o(op), .op_addr_o(op_addr), .op_data_o(op_data),
    .seq_err_o(seq_err), .clr_o(clr)
  );

  fci_wsm #(.AW(AW), .BLK_LOG2(BLK_LOG2), .BUSY_CYC(BUSY_CYC)) u_wsm (
    .clk(clk), .rst_n(rst_n), .vpp_ok_i(vpp_ok_i), .start_i(start), .op_i(op),
    .addr_i(op_addr), .data_i(op_data), .seq_err_i(seq_err), .clr_i(clr),
    .rd_addr_i(addr_i), .busy_o(busy), .status_o(status), .rd_data_o(arr_word)
  );

  always_comb begin
    case (mode)
      RD_ARRAY:  rd_word = arr_word;
      RD_STATUS: rd_word = {8'h00, status};
      RD_IDENT:  rd_word = addr_i[0] ? DEV_ID : MFR_ID;
      default:   rd_word = '0;
    endcase
  end

  assign rdata_oe_o = rst_n & ~cs_n & ~rd_n;
  assign rdata_o    = rdata_oe_o ? rd_word : 16'h0000;
endmodule

// File: tb/flash_cmd_if_test.sv
module flash_cmd_if_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int WAKE = 4;
  localparam logic [15:0] MFR = 16'h00B0;
  localparam logic [15:0] DEV = 16'h00EC;

  logic clk = 1'b0;
  logic rst_n, lockout_i, vpp_ok_i, cs_n, wr_n, rd_n;
  logic [AW-1:0] addr_i;
  logic [15:0] wdata_i, rdata_o;
  logic rdata_oe_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  flash_cmd_if #(.AW(AW), .BLK_LOG2(2), .BUSY_CYC(6), .WAKE_CYC(WAKE),
                 .MFR_ID(MFR), .DEV_ID(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .lockout_i(lockout_i), .vpp_ok_i(vpp_ok_i),
    .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge.
  task automatic wr_raw(logic c, logic w, logic [AW-1:0] a, logic [15:0] d);
    addr_i = a; wdata_i = d; cs_n = c; wr_n = w;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic wr_cmd(logic [AW-1:0] a, logic [15:0] d);
    wr_raw(1'b0, 1'b0, a, d);
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [15:0] v);
    addr_i = a; cs_n = 1'b0; rd_n = 1'b0;
    #1 v = rdata_o;
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_chk(string tag, logic [AW-1:0] a, logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic wait_ready();
    logic [15:0] v;
    for (int k = 0; k < 50; k++) begin
      rd(0, v);
      if (v[7]) return;
    end
    chk("R5 ready timeout", v, 16'h0080);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (WAKE) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rst_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; wdata_i = 16'h0090;
    #1;
    chk("R1 oe in reset", {15'd0, rdata_oe_o}, 16'h0000);
    chk("R1 data in reset", rdata_o, 16'h0000);
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    rst_n = 1'b1;
    repeat (WAKE) @(negedge clk);
    rd(3, v);
    chk("R1 array after reset", v, 16'hFFFF);
    wr_cmd(0, 16'h0070);
    rd_chk("R1 status after reset", 0, 16'h0080);
    wr_cmd(0, 16'h00FF);
  endtask

  task automatic t_wake();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (WAKE - 1) @(negedge clk);
    wr_cmd(0, 16'h0090);           // lands on edge WAKE: rejected
    rd_chk("R3 write in wake window", 0, 16'hFFFF);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (WAKE) @(negedge clk);
    wr_cmd(0, 16'h0090);           // lands on edge WAKE+1: accepted
    rd_chk("R3 first accepted write", 0, MFR);
    wr_cmd(0, 16'h00FF);
  endtask

  task automatic t_modes();
    wr_cmd(0, 16'h0090);
    rd_chk("R4 ident mfr", 0, MFR);
    rd_chk("R4 ident dev", 1, DEV);
    wr_cmd(0, 16'h0070);
    rd_chk("R4 status read", 5, 16'h0080);
    wr_cmd(0, 16'h00FF);
    rd_chk("R4 array read", 5, 16'hFFFF);
  endtask

  task automatic t_gate();
    wr_raw(1'b1, 1'b0, 0, 16'h0090);
    rd_chk("R2 cs high ignored", 0, 16'hFFFF);
    wr_raw(1'b0, 1'b1, 0, 16'h0090);
    rd_chk("R2 wr high ignored", 0, 16'hFFFF);
  endtask

  task automatic t_prog();
    wr_cmd(5, 16'h0040);
    wr_cmd(5, 16'h1234);
    rd_chk("R5 busy after data cycle", 0, 16'h0000);
    wait_ready();
    wr_cmd(0, 16'h00FF);
    rd_chk("R5 programmed word", 5, 16'h1234);
    wr_cmd(5, 16'h0010);
    wr_cmd(5, 16'hFF0F);
    wait_ready();
    wr_cmd(0, 16'h00FF);
    rd_chk("R5 program ANDs bits", 5, 16'h1204);
  endtask

  task automatic t_busy();
    wr_cmd(6, 16'h0040);
    wr_cmd(6, 16'h00FF);
    rd_chk("R9 busy status", 0, 16'h0000);
    wr_cmd(0, 16'h00FF);
    rd_chk("R9 read array ignored while busy", 6, 16'h0000);
    wr_cmd(0, 16'h0070);
    rd_chk("R9 read status honoured", 6, 16'h0000);
    wait_ready();
    rd_chk("R10 status kept after done", 6, 16'h0080);
    vpp_ok_i = 1'b0;
    repeat (2) @(negedge clk);
    vpp_ok_i = 1'b1;
    rd_chk("R10 status kept after vpp change", 6, 16'h0080);
    wr_cmd(0, 16'h00FF);
    rd_chk("R10 array after read array", 6, 16'h00FF);
  endtask

  task automatic t_erase();
    wr_cmd(8, 16'h0040);  wr_cmd(8, 16'h0000);  wait_ready();
    wr_cmd(11, 16'h0040); wr_cmd(11, 16'h00FF); wait_ready();
    wr_cmd(9, 16'h0020);  wr_cmd(9, 16'h00D0);
    rd_chk("R6 erase busy", 0, 16'h0000);
    wait_ready();
    wr_cmd(0, 16'h00FF);
    rd_chk("R6 erased word 8", 8, 16'hFFFF);
    rd_chk("R6 erased word 11", 11, 16'hFFFF);
    rd_chk("R6 other block untouched", 5, 16'h1204);
    wr_cmd(9, 16'h0020);
    wr_cmd(9, 16'h0033);
    rd_chk("R6 bad confirm error", 0, 16'h00B0);
    wr_cmd(0, 16'h0050);
    rd_chk("R12 clear status", 0, 16'h0080);
    wr_cmd(0, 16'h00FF);
  endtask

  task automatic t_lock();
    wr_cmd(0, 16'h0060); wr_cmd(0, 16'h0001); wait_ready();
    wr_cmd(1, 16'h0040); wr_cmd(1, 16'h0000);
    rd_chk("R7 locked program rejected", 0, 16'h0092);
    wr_cmd(2, 16'h0020); wr_cmd(2, 16'h00D0);
    rd_chk("R7 locked erase rejected", 0, 16'h00B2);
    wr_cmd(0, 16'h00FF);
    rd_chk("R7 locked word unchanged", 1, 16'hFFFF);
    wr_cmd(0, 16'h0050);
    wr_cmd(0, 16'h0060); wr_cmd(0, 16'h00D0); wait_ready();
    wr_cmd(1, 16'h0040); wr_cmd(1, 16'h0F0F); wait_ready();
    wr_cmd(0, 16'h00FF);
    rd_chk("R7 program after unlock", 1, 16'h0F0F);
  endtask

  task automatic t_vpp();
    wr_cmd(12, 16'h0040); wr_cmd(12, 16'h5555); wait_ready();
    vpp_ok_i = 1'b0;
    wr_cmd(13, 16'h0040); wr_cmd(13, 16'h0000);
    rd_chk("R8 program abort status", 0, 16'h0098);
    wr_cmd(0, 16'h0050);
    wr_cmd(12, 16'h0020); wr_cmd(12, 16'h00D0);
    rd_chk("R8 erase abort status", 0, 16'h00A8);
    vpp_ok_i = 1'b1;
    wr_cmd(0, 16'h0050);
    wr_cmd(0, 16'h00FF);
    rd_chk("R8 word 13 unchanged", 13, 16'hFFFF);
    rd_chk("R8 word 12 unchanged", 12, 16'h5555);
  endtask

  task automatic t_lockout();
    wr_cmd(0, 16'h0090);
    lockout_i = 1'b1; @(negedge clk); lockout_i = 1'b0;
    rd_chk("R11 lockout forces array", 1, 16'h0F0F);
    wr_cmd(2, 16'h0040);
    lockout_i = 1'b1; @(negedge clk); lockout_i = 1'b0;
    wr_cmd(2, 16'h0070);
    rd_chk("R11 pending dropped, status ready", 2, 16'h0080);
    wr_cmd(0, 16'h00FF);
    rd_chk("R11 pending dropped, word intact", 2, 16'hFFFF);
    lockout_i = 1'b1;
    wr_cmd(0, 16'h0090);
    lockout_i = 1'b0;
    rd_chk("R11 write ignored in lockout", 1, 16'h0F0F);
  endtask

  task automatic t_reset_clears();
    wr_cmd(0, 16'h0020); wr_cmd(0, 16'h0011);
    rd_chk("R12 error before reset", 0, 16'h00B0);
    do_reset();
    rd_chk("R12 array mode after reset", 5, 16'hFFFF);
    wr_cmd(0, 16'h0070);
    rd_chk("R12 status cleared by reset", 0, 16'h0080);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lockout_i = 1'b0; vpp_ok_i = 1'b1;
    cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; addr_i = '0; wdata_i = '0;
    @(negedge clk);
    t_reset();
    t_wake();
    t_modes();
    t_gate();
    t_prog();
    t_busy();
    t_erase();
    t_lock();
    t_vpp();
    t_lockout();
    t_reset_clears();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule